// File: doc/BRIEF.md
# Dual-Role Double-Buffered SPI Controller

This block is an SPI peripheral whose single shift register is shared between two roles. With `cfg_master` high it generates the serial clock from the system clock, drives MOSI, samples MISO and optionally drives a select line low for each frame. With `cfg_master` low it follows an external master, taking its clock, data and select from the pads and returning data on MISO. Frames are 8 or 16 bits long (`cfg_wide`), sent most significant bit first. Timing is fixed to clock-idle-low, with data sampled on the rising edge and changed on the falling edge.

The host side is two streams. The transmit stream writes a one-entry holding register. A frame can be queued there while the previous frame is still shifting. The receive stream presents the last completed frame from a separate one-entry buffer. `tx_ready` doubles as the transmit-empty flag and `rx_valid` as the receive-full flag.

Back-pressure works as follows. A write is taken only on a cycle where both `tx_valid` and `tx_ready` are high. `tx_ready` drops until the holding word is moved into the shifter. The receive buffer holds its value while `rx_ready` is low. If a further frame completes before the buffer is read, that frame is dropped and `overrun` is raised. Configuration inputs must only change while no frame is in progress. In slave mode the external clock must be several system clocks per phase, because the slave pads pass through a two-stage synchronizer.

Top module: `spi_dual_role`

## Requirements
- R1: In master mode `sck_o` is low whenever no frame is in progress, and `ss_n_o` is low exactly while a frame is in progress. A frame starts only when the holding register is full.
- R2: In master mode each `sck_o` period lasts 2*(`cfg_div`+1) system clocks. `cfg_div` ranges 0..127, giving divisors 2 to 256.
- R3: A master frame is full duplex and MSB first. MOSI carries the queued word and the bits sampled from MISO on rising edges form the received word.
- R4: With `cfg_wide`=1 a frame has 16 clock pulses and uses all of `tx_data`. With `cfg_wide`=0 it has 8 pulses, sends `tx_data[7:0]`, and returns the received byte in `rx_data[7:0]` with `rx_data[15:8]`=0.
- R5: `tx_ready` is high exactly when the holding register is empty. A write may be queued while a frame is shifting. After an accepted write `tx_ready` stays low until that word is loaded into the shifter.
- R6: `rx_valid` rises when a frame completes. `rx_data` holds steady while `rx_valid` is high and `rx_ready` is low. A cycle with both high empties the buffer.
- R7: A frame that completes while the buffer is full and not being read is discarded, and `overrun` is set. `overrun` stays set until the next read and is cleared by that read.
- R8: In slave mode `sck_oe`, `mosi_oe` and `ss_n_oe` are low. `miso_oe` is high only while `ss_n_i` is low.
- R9: In slave mode a low-going `ss_n_i` loads the holding word into the shifter, or zero if the holding register is empty. Each rising `sck_i` samples `mosi_i`, and `miso_o` presents the outgoing bits MSB first.
- R10: In master mode `sck_oe` and `mosi_oe` are high, `miso_oe` is low, and `ss_n_oe` follows `cfg_ss_out`.
- R11: In slave mode, raising `ss_n_i` before a frame is complete discards the partial frame. No `rx_valid` results, and the next frame starts from bit zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_master | input | 1 | 1 = master role, 0 = slave role |
| cfg_wide | input | 1 | 1 = 16-bit frames, 0 = 8-bit frames |
| cfg_ss_out | input | 1 | Master drives the select pad when 1 |
| cfg_div | input | 7 | Master half-period minus one, in system clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding register empty; write accepted |
| tx_data | input | 16 | Transmit word |
| rx_valid | output | 1 | Receive buffer full |
| rx_ready | input | 1 | Host reads the receive buffer |
| rx_data | output | 16 | Received frame |
| overrun | output | 1 | A frame was dropped because the buffer was full |
| sck_i | input | 1 | Serial clock pad input (slave) |
| sck_o | output | 1 | Serial clock pad output (master) |
| sck_oe | output | 1 | Serial clock pad drive enable |
| mosi_i | input | 1 | MOSI pad input (slave) |
| mosi_o | output | 1 | MOSI pad output (master) |
| mosi_oe | output | 1 | MOSI pad drive enable |
| miso_i | input | 1 | MISO pad input (master) |
| miso_o | output | 1 | MISO pad output (slave) |
| miso_oe | output | 1 | MISO pad drive enable |
| ss_n_i | input | 1 | Select pad input, active low (slave) |
| ss_n_o | output | 1 | Select pad output, active low (master) |
| ss_n_oe | output | 1 | Select pad drive enable |

## Verification
Master frames use the patterns all-zero, all-one, lone MSB, lone LSB and several arithmetic words, while the bench's model slave returns a different word. This separates bit-order reversal, stuck data lines and crossed MOSI/MISO routing. The sweep covers both frame widths and several divisors, which tells apart a wrong pulse count or byte selection from a wrong clock period. Slave frames use the same word set under an externally paced clock, with an empty holding register and an aborted frame as corner cases. Back-to-back queued writes and an unread buffer separate correct double buffering from overwrite or premature drop.

// File: rtl/spi_dr_pkg.sv
package spi_dr_pkg;
  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } spi_role_e;

  typedef struct packed {
    logic clr;
    logic load;
    logic sample;
    logic shift;
  } shift_ctl_t;
endpackage

// File: rtl/spi_dr_sync.sv
module spi_dr_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  if (STAGES == 1) begin : g_one
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg <= RST_VAL;
      else        stg <= d;
  end else begin : g_chain
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_dr_sck_gen.sv
module spi_dr_sck_gen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] half_m1,
  output logic             sck,
  output logic             rise_p,
  output logic             fall_p
);
  logic [DIV_W-1:0] cnt;
  logic             tick;

  assign tick   = run && (cnt == half_m1);
  assign rise_p = tick && !sck;
  assign fall_p = tick && sck;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      sck <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      sck <= !sck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/spi_dr_shifter.sv
module spi_dr_shifter
  import spi_dr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wide,
  input  shift_ctl_t   ctl,
  input  logic [W-1:0] load_data,
  input  logic         in_bit,
  output logic         out_bit,
  output logic         done,
  output logic [W-1:0] frame
);
  localparam int HW = W / 2;
  localparam int CW = $clog2(W);

  logic [W-1:0]  sh;
  logic          smp;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic [W-1:0]  nxt;

  assign last    = wide ? CW'(W - 1) : CW'(HW - 1);
  assign nxt     = {sh[W-2:0], smp};
  assign done    = ctl.shift && !ctl.clr && (cnt == last);
  assign frame   = wide ? nxt : {{(W-HW){1'b0}}, nxt[HW-1:0]};
  assign out_bit = sh[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      smp <= 1'b0;
      cnt <= '0;
    end else if (ctl.clr) begin
      cnt <= '0;
    end else if (ctl.load) begin
      sh  <= load_data;
      cnt <= '0;
    end else begin
      if (ctl.sample) smp <= in_bit;
      if (ctl.shift) begin
        sh  <= nxt;
        cnt <= done ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_dual_role.sv
module spi_dual_role
  import spi_dr_pkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DIV_W = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_master,
  input  logic               cfg_wide,
  input  logic               cfg_ss_out,
  input  logic [DIV_W-1:0]   cfg_div,
  input  logic               tx_valid,
  output logic               tx_ready,
  input  logic [FRAME_W-1:0] tx_data,
  output logic               rx_valid,
  input  logic               rx_ready,
  output logic [FRAME_W-1:0] rx_data,
  output logic               overrun,
  input  logic               sck_i,
  output logic               sck_o,
  output logic               sck_oe,
  input  logic               mosi_i,
  output logic               mosi_o,
  output logic               mosi_oe,
  input  logic               miso_i,
  output logic               miso_o,
  output logic               miso_oe,
  input  logic               ss_n_i,
  output logic               ss_n_o,
  output logic               ss_n_oe
);
  localparam int HALF_W = FRAME_W / 2;

  spi_role_e    role;
  logic         is_m;
  logic         ss_s, sck_s, mosi_s, ss_d, sck_d;
  logic         slv_act, slv_ss_fall, slv_ss_rise, slv_rise, slv_fall;
  logic         busy, start, m_sck, m_rise, m_fall;
  logic         hold_full, accept, consume;
  logic [FRAME_W-1:0] hold, ld_data, frame;
  logic         sh_out, done;
  shift_ctl_t   ctl;

  assign role = spi_role_e'(cfg_master);
  assign is_m = (role == ROLE_MASTER);

  spi_dr_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ss_n_i, sck_i, mosi_i}),
    .q({ss_s, sck_s, mosi_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_d  <= 1'b1;
      sck_d <= 1'b0;
    end else begin
      ss_d  <= ss_s;
      sck_d <= sck_s;
    end
  end

  assign slv_act     = !is_m && !ss_s;
  assign slv_ss_fall = !is_m && ss_d && !ss_s;
  assign slv_ss_rise = !is_m && !ss_d && ss_s;
  assign slv_rise    = slv_act && sck_s && !sck_d;
  assign slv_fall    = slv_act && !sck_s && sck_d;

  spi_dr_sck_gen #(.DIV_W(DIV_W)) u_sck (
    .clk(clk), .rst_n(rst_n), .run(busy), .half_m1(cfg_div),
    .sck(m_sck), .rise_p(m_rise), .fall_p(m_fall)
  );

  assign start   = is_m && !busy && hold_full;
  assign ld_data = !hold_full ? '0 :
                   cfg_wide   ? hold : {hold[HALF_W-1:0], {(FRAME_W-HALF_W){1'b0}}};

  always_comb begin
    ctl.clr    = slv_ss_rise;
    ctl.load   = start || slv_ss_fall || (slv_act && done);
    ctl.sample = is_m ? (busy && m_rise) : slv_rise;
    ctl.shift  = is_m ? (busy && m_fall) : slv_fall;
  end

  spi_dr_shifter #(.W(FRAME_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .wide(cfg_wide), .ctl(ctl),
    .load_data(ld_data), .in_bit(is_m ? miso_i : mosi_s),
    .out_bit(sh_out), .done(done), .frame(frame)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                busy <= 1'b0;
    else if (!is_m)            busy <= 1'b0;
    else if (start)            busy <= 1'b1;
    else if (done)             busy <= 1'b0;
  end

  assign tx_ready = !hold_full;
  assign accept   = tx_valid && tx_ready;
  assign consume  = ctl.load && hold_full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold      <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold      <= tx_data;
    end else if (consume) begin
      hold_full <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_valid <= 1'b0;
      rx_data  <= '0;
      overrun  <= 1'b0;
    end else begin
      if (rx_valid && rx_ready) begin
        rx_valid <= 1'b0;
        overrun  <= 1'b0;
      end
      if (done) begin
        if (rx_valid && !rx_ready) begin
          overrun <= 1'b1;
        end else begin
          rx_valid <= 1'b1;
          rx_data  <= frame;
        end
      end
    end
  end

  assign sck_o   = is_m ? m_sck : 1'b0;
  assign sck_oe  = is_m;
  assign mosi_o  = sh_out;
  assign mosi_oe = is_m;
  assign miso_o  = sh_out;
  assign miso_oe = slv_act;
  assign ss_n_o  = !busy;
  assign ss_n_oe = is_m && cfg_ss_out;
endmodule

// File: rtl/spi_dual_role_chk.sv
module spi_dual_role_chk #(
  parameter int FRAME_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_master,
  input logic               cfg_ss_out,
  input logic               tx_valid,
  input logic               tx_ready,
  input logic               rx_valid,
  input logic               rx_ready,
  input logic [FRAME_W-1:0] rx_data,
  input logic               overrun,
  input logic               sck_o,
  input logic               sck_oe,
  input logic               mosi_oe,
  input logic               miso_oe,
  input logic               ss_n_o,
  input logic               ss_n_oe
);
  assert_sck_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_master && ss_n_o) |-> !sck_o);

  assert_hold_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready) |=> !tx_ready);

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !rx_ready) |=> (rx_valid && $stable(rx_data)));

  assert_ovr_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !(rx_valid && rx_ready)) |=> overrun);

  assert_ovr_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> !overrun);

  assert_ovr_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rx_valid);

  assert_slave_pads_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_master |-> (!sck_oe && !mosi_oe && !ss_n_oe));

  assert_master_pads_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_master |-> (sck_oe && mosi_oe && !miso_oe && (ss_n_oe == cfg_ss_out)));
endmodule

bind spi_dual_role spi_dual_role_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_ss_out(cfg_ss_out),
  .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid),
  .rx_ready(rx_ready), .rx_data(rx_data), .overrun(overrun),
  .sck_o(sck_o), .sck_oe(sck_oe), .mosi_oe(mosi_oe), .miso_oe(miso_oe),
  .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe)
);

// File: tb/spi_dual_role_tb.sv
module spi_dual_role_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_master = 1'b1, cfg_wide = 1'b1, cfg_ss_out = 1'b1;
  logic [6:0] cfg_div = '0;
  logic tx_valid = 1'b0, rx_ready = 1'b0;
  logic [15:0] tx_data = '0;
  logic tx_ready, rx_valid, overrun;
  logic [15:0] rx_data;
  logic sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1, miso_i;
  logic sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_n_o, ss_n_oe;

  int total = 0, bad = 0, cyc = 0;
  int rises = 0, prev_rise = 0, last_per = 0;
  logic [15:0] bs_sh = '0, bs_in = '0, bs_word = '0;
  logic bs_ss_prev = 1'b1;

  always #2 clk = ~clk;

  spi_dual_role u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_wide(cfg_wide),
    .cfg_ss_out(cfg_ss_out), .cfg_div(cfg_div),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .overrun(overrun),
    .sck_i(sck_i), .sck_o(sck_o), .sck_oe(sck_oe),
    .mosi_i(mosi_i), .mosi_o(mosi_o), .mosi_oe(mosi_oe),
    .miso_i(miso_i), .miso_o(miso_o), .miso_oe(miso_oe),
    .ss_n_i(ss_n_i), .ss_n_o(ss_n_o), .ss_n_oe(ss_n_oe)
  );

  // model slave on the master-side pads
  assign miso_i = bs_sh[15];
  always @(ss_n_o or negedge sck_o) begin
    if (ss_n_o !== bs_ss_prev) begin
      if (ss_n_o == 1'b0) bs_sh = cfg_wide ? bs_word : {bs_word[7:0], 8'h00};
      bs_ss_prev = ss_n_o;
    end else if (sck_o == 1'b0) begin
      bs_sh = {bs_sh[14:0], 1'b0};
    end
  end
  always @(posedge sck_o) begin
    bs_in = {bs_in[14:0], mosi_o};
    if (rises > 0) last_per = cyc - prev_rise;
    prev_rise = cyc;
    rises = rises + 1;
  end

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 150000) begin
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 150000);
      summary();
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int k);
    case (k)
      0: pat = 16'h0000;
      1: pat = 16'hFFFF;
      2: pat = 16'h8000;
      3: pat = 16'h0001;
      default: pat = 16'(k * 16'h3B5D) ^ 16'hA5C3;
    endcase
  endfunction

  function automatic logic [15:0] msk(input logic [15:0] v);
    msk = cfg_wide ? v : {8'h00, v[7:0]};
  endfunction

  task automatic do_reset();
    @(negedge clk) rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic push(input logic [15:0] w);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data = w;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_rx(input string tag);
    int n = 0;
    while (!rx_valid && n < 5000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, rx_valid, 1'b1);
  endtask

  task automatic pop();
    @(negedge clk) rx_ready = 1'b1;
    @(negedge clk) rx_ready = 1'b0;
  endtask

  task automatic m_xfer(input logic [15:0] tx, input logic [15:0] sw);
    bs_word = sw;
    rises = 0;
    push(tx);
    @(negedge clk);
    chk("R1 select low in frame", ss_n_o, 1'b0);
    wait_rx("R6 rx_valid after master frame");
    chk("R3 master rx word", rx_data, msk(sw));
    chk("R3 mosi word", msk(bs_in), msk(tx));
    chk("R4 pulse count", rises, cfg_wide ? 16 : 8);
    chk("R2 sck period", last_per, 2 * (cfg_div + 1));
    chk("R1 idle after frame", {ss_n_o, sck_o}, 2'b10);
    pop();
    chk("R6 rx emptied by read", rx_valid, 1'b0);
  endtask

  task automatic s_xfer(input logic [15:0] mo, input logic [15:0] txw, input bit load_tx);
    logic [15:0] got = '0;
    int nb = cfg_wide ? 16 : 8;
    if (load_tx) push(txw);
    @(negedge clk) ss_n_i = 1'b0;
    repeat (10) @(negedge clk);
    chk("R8 miso driven while selected", miso_oe, 1'b1);
    for (int i = 0; i < nb; i++) begin
      mosi_i = mo[nb-1-i];
      repeat (8) @(negedge clk);
      got = {got[14:0], miso_o};
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk("R9 slave rx_valid", rx_valid, 1'b1);
    chk("R9 slave rx word", rx_data, msk(mo));
    chk("R9 slave miso word", msk(got), load_tx ? msk(txw) : 16'h0000);
    ss_n_i = 1'b1;
    repeat (10) @(negedge clk);
    chk("R8 miso released when deselected", miso_oe, 1'b0);
    pop();
  endtask

  initial begin
    do_reset();
    chk("R1 reset idle pads", {ss_n_o, sck_o}, 2'b10);
    chk("R5 reset tx_ready", tx_ready, 1'b1);
    chk("R6 reset rx_valid", rx_valid, 1'b0);
    chk("R7 reset overrun", overrun, 1'b0);
    chk("R10 master pad enables", {sck_oe, mosi_oe, miso_oe, ss_n_oe}, 4'b1101);

    // master sweep: widths x divisors x patterns
    for (int w = 0; w < 2; w++) begin
      for (int d = 0; d < 3; d++) begin
        cfg_wide = w[0];
        cfg_div = (d == 0) ? 7'd0 : (d == 1) ? 7'd1 : 7'd3;
        for (int k = 0; k < 6; k++) m_xfer(pat(k), ~pat(k + 3));
      end
    end

    // double buffering: queue B while A shifts
    cfg_wide = 1'b1;
    cfg_div = 7'd0;
    bs_word = 16'h1234;
    push(16'hC0DE);
    repeat (2) @(negedge clk);
    chk("R5 queue allowed while shifting", tx_ready, 1'b1);
    push(16'h5A0F);
    chk("R5 holding full after write", tx_ready, 1'b0);
    wait_rx("R6 first queued frame");
    chk("R5 first frame mosi", bs_in, 16'hC0DE);
    pop();
    wait_rx("R6 second queued frame");
    chk("R5 second frame mosi", bs_in, 16'h5A0F);
    chk("R5 second frame rx", rx_data, 16'h1234);
    pop();

    // overrun
    bs_word = 16'hBEEF;
    push(16'h0F0F);
    wait_rx("R7 first frame");
    bs_word = 16'h7777;
    push(16'hF0F0);
    repeat (60) @(negedge clk);
    chk("R7 overrun set", overrun, 1'b1);
    chk("R7 old frame kept", rx_data, 16'hBEEF);
    pop();
    chk("R7 overrun cleared by read", overrun, 1'b0);
    chk("R7 dropped frame not presented", rx_valid, 1'b0);

    // slave role
    cfg_master = 1'b0;
    do_reset();
    chk("R8 slave pad enables", {sck_oe, mosi_oe, miso_oe, ss_n_oe}, 4'b0000);
    for (int w = 0; w < 2; w++) begin
      cfg_wide = w[0];
      for (int k = 0; k < 6; k++) s_xfer(pat(k + 2), pat(k), 1'b1);
    end
    cfg_wide = 1'b1;
    s_xfer(16'h9C3A, 16'h0000, 1'b0);

    // abort mid-frame
    @(negedge clk) ss_n_i = 1'b0;
    repeat (10) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      mosi_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (20) @(negedge clk);
    chk("R11 aborted frame not delivered", rx_valid, 1'b0);
    s_xfer(16'h4D21, 16'hE817, 1'b1);

    summary();
    $finish;
  end
endmodule